// File: doc/BRIEF.md
# Stepping Address Generator with Modulo and Mirrored Ordering

This block produces memory addresses for a signal-processing datapath. A pointer is formed from a programmed base address plus an offset taken from an internal index. It offers three stepping modes. Linear mode is a plain stride. Circular mode confines the index to a buffer of any length, so that an endless sample stream can be held in a fixed window. Mirrored mode reverses the low bits of the index before adding it to the base, so that the data for a radix-2 transform can be put in or out of order without extra passes.

The surrounding controller drives the base, length, stride, mode code and mirror width. It pulses `restart` to zero the index and to apply a new mode and width. It then raises `step_en` once for each address it needs. The address for a step appears, qualified by `addr_valid`, on the cycle after the strobe.

Top module: `stride_agu`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears `addr_valid` and `addr_out` to 0 and the index to 0, and selects linear mode with the full mirror width, whatever the mode inputs say.
- R2: `addr_valid` is 1 in exactly the cycles that follow a cycle with `step_en`=1 and `restart`=0. Otherwise `addr_valid` is 0 and `addr_out` keeps its previous value.
- R3: In linear mode (mode code 0), a step outputs `cfg_base` + index, taken modulo 2^ADDR_W, and then adds `cfg_step` to the index.
- R4: In circular mode (mode code 1), the next index is index + `cfg_step`, with `cfg_len` subtracted when that sum is greater than or equal to `cfg_len`. With `cfg_step` < `cfg_len`, the offset stays below `cfg_len`.
- R5: In circular mode with `cfg_len` = 0, the index is forced to 0, so every step outputs `cfg_base`.
- R6: In mirrored mode (mode code 2) with width W, the offset is the low W bits of the index in reversed order. For W=3, indices 0..7 give offsets 0,4,2,6,1,5,3,7.
- R7: In mirrored mode, the index advances by `cfg_step` modulo 2^W. Index bits at or above W are always zero and do not affect the offset.
- R8: The mirror width is taken from `cfg_rev_bits`. A value of 0 is treated as 1, and values above 10 are treated as 10.
- R9: `restart` zeroes the index at the next edge and captures the mode code and the mirror width. When `restart` and `step_en` arrive together, `restart` wins and no address is produced.
- R10: A change to `cfg_mode` or `cfg_rev_bits` without a restart has no effect on the stepping.
- R11: Mode code 3 behaves as linear mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_base | input | ADDR_W | Base address added to every offset |
| cfg_len | input | LEN_W | Buffer length for circular mode |
| cfg_step | input | LEN_W | Index increment per step |
| cfg_mode | input | 2 | Mode code: 0 linear, 1 circular, 2 mirrored, 3 linear |
| cfg_rev_bits | input | 4 | Mirror width in bits (clamped to 1..10) |
| restart | input | 1 | Zero the index and capture mode and width |
| step_en | input | 1 | Produce one address and advance the index |
| addr_out | output | ADDR_W | Registered address |
| addr_valid | output | 1 | High for one cycle per accepted step |

## Verification
The assertions check on every cycle the rules that hold for any input sequence:
- the timing of `addr_valid` and the holding of the address between steps;
- the zeroing of the index on restart;
- a circular index that never leaves its buffer;
- a mirrored index with no bits above the width;
- a width that stays in range;
- a mode that changes only on restart.

The actual address values can only be shown by the bench's scenarios:
- the exact wrap points in circular mode;
- the mirrored orderings for several widths and strides;
- the clamping of the width codes;
- the zero-length buffer;
- the 16-bit address rollover;
- the priority of restart over step;
- a mode input that is ignored until a restart.

// File: rtl/stride_agu_pkg.sv
package stride_agu_pkg;

    localparam int WSEL_W = 4;

    typedef enum logic [1:0] {
        MODE_LIN  = 2'd0,
        MODE_CIRC = 2'd1,
        MODE_REV  = 2'd2
    } agu_mode_e;

    typedef struct packed {
        agu_mode_e          mode;
        logic [WSEL_W-1:0]  width;
    } agu_ctl_t;

    function automatic agu_mode_e decode_mode(input logic [1:0] code);
        case (code)
            2'd1:    return MODE_CIRC;
            2'd2:    return MODE_REV;
            default: return MODE_LIN;
        endcase
    endfunction

    function automatic logic [WSEL_W-1:0] clamp_width(input logic [WSEL_W-1:0] raw,
                                                      input logic [WSEL_W-1:0] wmax);
        if (raw == '0)
            return WSEL_W'(1);
        else if (raw > wmax)
            return wmax;
        else
            return raw;
    endfunction

endpackage

// File: rtl/stride_agu_next.sv
module stride_agu_next
    import stride_agu_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 12
) (
    input  agu_mode_e            mode,
    input  logic [WSEL_W-1:0]    width,
    input  logic [ADDR_W-1:0]    idx,
    input  logic [LEN_W-1:0]     step,
    input  logic [LEN_W-1:0]     len,
    output logic [ADDR_W-1:0]    idx_nxt
);
    localparam int SUM_W = ADDR_W + 1;

    logic [SUM_W-1:0]  sum;
    logic [SUM_W-1:0]  len_ext;
    logic [SUM_W-1:0]  wrapped;
    logic [ADDR_W-1:0] ones;
    logic [ADDR_W-1:0] mask;

    assign ones    = '1;
    assign mask    = ~(ones << width);
    assign sum     = {1'b0, idx} + SUM_W'(step);
    assign len_ext = SUM_W'(len);
    assign wrapped = sum - len_ext;

    always_comb begin
        case (mode)
            MODE_CIRC: begin
                if (len == '0)
                    idx_nxt = '0;
                else if (sum >= len_ext)
                    idx_nxt = wrapped[ADDR_W-1:0];
                else
                    idx_nxt = sum[ADDR_W-1:0];
            end
            MODE_REV:  idx_nxt = sum[ADDR_W-1:0] & mask;
            default:   idx_nxt = sum[ADDR_W-1:0];
        endcase
    end
endmodule

// File: rtl/stride_agu_offset.sv
module stride_agu_offset
    import stride_agu_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int REV_MAX = 10
) (
    input  agu_mode_e            mode,
    input  logic [WSEL_W-1:0]    width,
    input  logic [ADDR_W-1:0]    idx,
    output logic [ADDR_W-1:0]    offset
);
    localparam int PAD_W = ADDR_W - REV_MAX;

    logic [REV_MAX-1:0] low;
    logic [REV_MAX-1:0] mir;
    logic [REV_MAX-1:0] mir_sh;
    logic [WSEL_W-1:0]  sh_amt;

    assign low = idx[REV_MAX-1:0];

    for (genvar k = 0; k < REV_MAX; k++) begin : g_mirror
        assign mir[k] = low[REV_MAX-1-k];
    end

    assign sh_amt = WSEL_W'(REV_MAX) - width;
    assign mir_sh = mir >> sh_amt;

    generate
        if (PAD_W > 0) begin : g_pad
            assign offset = (mode == MODE_REV) ? {{PAD_W{1'b0}}, mir_sh} : idx;
        end else begin : g_nopad
            assign offset = (mode == MODE_REV) ? mir_sh : idx;
        end
    endgenerate
endmodule

// File: rtl/stride_agu.sv
module stride_agu
    import stride_agu_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int LEN_W   = 12,
    parameter int REV_MAX = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   cfg_base,
    input  logic [LEN_W-1:0]    cfg_len,
    input  logic [LEN_W-1:0]    cfg_step,
    input  logic [1:0]          cfg_mode,
    input  logic [3:0]          cfg_rev_bits,
    input  logic                restart,
    input  logic                step_en,
    output logic [ADDR_W-1:0]   addr_out,
    output logic                addr_valid
);
    localparam logic [WSEL_W-1:0] WMAX = WSEL_W'(REV_MAX);

    agu_ctl_t           ctl_q;
    logic [ADDR_W-1:0]  idx_q;
    logic [ADDR_W-1:0]  idx_nxt;
    logic [ADDR_W-1:0]  offset;
    logic [ADDR_W-1:0]  addr_q;
    logic               vld_q;

    stride_agu_next #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W)
    ) u_next (
        .mode    (ctl_q.mode),
        .width   (ctl_q.width),
        .idx     (idx_q),
        .step    (cfg_step),
        .len     (cfg_len),
        .idx_nxt (idx_nxt)
    );

    stride_agu_offset #(
        .ADDR_W  (ADDR_W),
        .REV_MAX (REV_MAX)
    ) u_offset (
        .mode   (ctl_q.mode),
        .width  (ctl_q.width),
        .idx    (idx_q),
        .offset (offset)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q       <= '0;
            ctl_q.mode  <= MODE_LIN;
            ctl_q.width <= WMAX;
            addr_q      <= '0;
            vld_q       <= 1'b0;
        end else if (restart) begin
            idx_q       <= '0;
            ctl_q.mode  <= decode_mode(cfg_mode);
            ctl_q.width <= clamp_width(cfg_rev_bits, WMAX);
            vld_q       <= 1'b0;
        end else if (step_en) begin
            addr_q      <= cfg_base + offset;
            idx_q       <= idx_nxt;
            vld_q       <= 1'b1;
        end else begin
            vld_q       <= 1'b0;
        end
    end

    assign addr_out   = addr_q;
    assign addr_valid = vld_q;
endmodule

// File: rtl/stride_agu_chk.sv
module stride_agu_chk
    import stride_agu_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int LEN_W   = 12,
    parameter int REV_MAX = 10
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 restart,
    input logic                 step_en,
    input logic [LEN_W-1:0]     cfg_len,
    input logic [LEN_W-1:0]     cfg_step,
    input logic [ADDR_W-1:0]    addr_out,
    input logic                 addr_valid,
    input logic [ADDR_W-1:0]    idx_q,
    input agu_mode_e            mode_q,
    input logic [WSEL_W-1:0]    width_q
);
    assert_valid_on_step_R2: assert property (@(posedge clk) disable iff (rst)
        (step_en && !restart) |=> addr_valid);

    assert_valid_low_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (!step_en || restart) |=> !addr_valid);

    assert_addr_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!step_en || restart) |=> $stable(addr_out));

    assert_restart_zero_R9: assert property (@(posedge clk) disable iff (rst)
        restart |=> (idx_q == '0));

    assert_circ_bound_R4: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_CIRC && step_en && !restart &&
         idx_q < ADDR_W'(cfg_len) && cfg_step < cfg_len)
        |=> (idx_q < ADDR_W'($past(cfg_len))));

    assert_rev_high_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_REV) |-> ((idx_q >> width_q) == '0));

    assert_width_range_R8: assert property (@(posedge clk) disable iff (rst)
        (width_q >= WSEL_W'(1)) && (width_q <= WSEL_W'(REV_MAX)));

    assert_mode_stable_R10: assert property (@(posedge clk) disable iff (rst)
        !restart |=> ($stable(mode_q) && $stable(width_q)));
endmodule

bind stride_agu stride_agu_chk #(
    .ADDR_W  (ADDR_W),
    .LEN_W   (LEN_W),
    .REV_MAX (REV_MAX)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .restart    (restart),
    .step_en    (step_en),
    .cfg_len    (cfg_len),
    .cfg_step   (cfg_step),
    .addr_out   (addr_out),
    .addr_valid (addr_valid),
    .idx_q      (idx_q),
    .mode_q     (ctl_q.mode),
    .width_q    (ctl_q.width)
);

// File: tb/stride_agu_bench.sv
module stride_agu_bench;
    localparam int ADDR_W = 16;
    localparam int LEN_W  = 12;
    localparam int NVEC   = 11;

    typedef struct packed {
        logic [1:0]        mode;
        logic [3:0]        wid;
        logic [11:0]       len;
        logic [11:0]       step;
        logic [15:0]       base;
        logic [3:0][15:0]  exp;
    } vec_t;

    // exp packs the expected addresses with the first one in the low slot
    localparam vec_t VECS [NVEC] = '{
        '{2'd0, 4'd0,  12'd0, 12'd3, 16'h1000, {16'h1009, 16'h1006, 16'h1003, 16'h1000}},
        '{2'd1, 4'd0,  12'd5, 12'd2, 16'h0200, {16'h0201, 16'h0204, 16'h0202, 16'h0200}},
        '{2'd1, 4'd0,  12'd7, 12'd6, 16'h0300, {16'h0304, 16'h0305, 16'h0306, 16'h0300}},
        '{2'd2, 4'd3,  12'd0, 12'd1, 16'h0400, {16'h0406, 16'h0402, 16'h0404, 16'h0400}},
        '{2'd2, 4'd4,  12'd0, 12'd1, 16'h0800, {16'h080C, 16'h0804, 16'h0808, 16'h0800}},
        '{2'd2, 4'd3,  12'd0, 12'd3, 16'h0000, {16'h0004, 16'h0003, 16'h0006, 16'h0000}},
        '{2'd3, 4'd0,  12'd0, 12'd1, 16'h0050, {16'h0053, 16'h0052, 16'h0051, 16'h0050}},
        '{2'd2, 4'd0,  12'd0, 12'd1, 16'h0010, {16'h0011, 16'h0010, 16'h0011, 16'h0010}},
        '{2'd2, 4'd15, 12'd0, 12'd1, 16'h0000, {16'h0300, 16'h0100, 16'h0200, 16'h0000}},
        '{2'd1, 4'd0,  12'd0, 12'd4, 16'h0060, {16'h0060, 16'h0060, 16'h0060, 16'h0060}},
        '{2'd0, 4'd0,  12'd0, 12'd1, 16'hFFFE, {16'h0001, 16'h0000, 16'hFFFF, 16'hFFFE}}
    };

    function automatic string vec_tag(input int i);
        case (i)
            0, 10:   return "R3";
            1, 2:    return "R4";
            3, 4:    return "R6";
            5:       return "R7";
            6:       return "R11";
            7, 8:    return "R8";
            default: return "R5";
        endcase
    endfunction

    function automatic logic [15:0] mirror3(input int v);
        logic [2:0] b;
        b = 3'(v);
        return {13'd0, b[0], b[1], b[2]};
    endfunction

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] cfg_base = '0;
    logic [LEN_W-1:0]  cfg_len = '0;
    logic [LEN_W-1:0]  cfg_step = '0;
    logic [1:0]        cfg_mode = '0;
    logic [3:0]        cfg_rev_bits = '0;
    logic              restart = 1'b0;
    logic              step_en = 1'b0;
    logic [ADDR_W-1:0] addr_out;
    logic              addr_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    stride_agu #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .REV_MAX(10)) u_stride_agu (
        .clk          (clk),
        .rst          (rst),
        .cfg_base     (cfg_base),
        .cfg_len      (cfg_len),
        .cfg_step     (cfg_step),
        .cfg_mode     (cfg_mode),
        .cfg_rev_bits (cfg_rev_bits),
        .restart      (restart),
        .step_en      (step_en),
        .addr_out     (addr_out),
        .addr_valid   (addr_valid)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [16:0] act, input logic [16:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // called just after a falling edge; leaves just after the next falling edge
    task automatic restart_with(input logic [1:0] m, input logic [3:0] w,
                                input logic [11:0] l, input logic [11:0] s,
                                input logic [15:0] b);
        cfg_mode = m; cfg_rev_bits = w; cfg_len = l; cfg_step = s; cfg_base = b;
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
    endtask

    task automatic step_once(input logic [15:0] exp, input string tag);
        step_en = 1'b1;
        @(negedge clk);
        step_en = 1'b0;
        chk(addr_valid && addr_out == exp, tag, {addr_valid, addr_out}, {1'b1, exp});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: outputs cleared by reset
        chk(!addr_valid && addr_out == '0, "R1", {addr_valid, addr_out}, 17'd0);

        // R1/R10: reset mode is linear; circular code without restart is ignored
        cfg_mode = 2'd1; cfg_len = 12'd2; cfg_step = 12'd1; cfg_base = 16'h0020;
        step_once(16'h0020, "R1");
        step_once(16'h0021, "R1");
        step_once(16'h0022, "R10");

        // R2: idle cycle drops valid and holds the address
        @(negedge clk);
        chk(!addr_valid && addr_out == 16'h0022, "R2", {addr_valid, addr_out}, {1'b0, 16'h0022});

        for (int i = 0; i < NVEC; i++) begin
            restart_with(VECS[i].mode, VECS[i].wid, VECS[i].len, VECS[i].step, VECS[i].base);
            for (int k = 0; k < 4; k++) begin
                step_once(VECS[i].exp[k], vec_tag(i));
            end
        end

        // R6: full 3-bit mirrored cycle, then back to the first slot
        restart_with(2'd2, 4'd3, 12'd0, 12'd1, 16'h0100);
        for (int k = 0; k < 9; k++) begin
            step_once(16'h0100 + mirror3(k), "R6");
        end

        // R9: restart beats a simultaneous step
        restart_with(2'd0, 4'd0, 12'd0, 12'd5, 16'h0040);
        step_once(16'h0040, "R9");
        step_once(16'h0045, "R9");
        step_en = 1'b1; restart = 1'b1;
        @(negedge clk);
        step_en = 1'b0; restart = 1'b0;
        chk(!addr_valid && addr_out == 16'h0045, "R9", {addr_valid, addr_out}, {1'b0, 16'h0045});
        step_once(16'h0040, "R9");

        // R10: mode input changed mid-run stays ignored
        restart_with(2'd1, 4'd0, 12'd3, 12'd2, 16'h0070);
        step_once(16'h0070, "R4");
        step_once(16'h0072, "R4");
        step_once(16'h0071, "R4");
        cfg_mode = 2'd0;
        step_once(16'h0070, "R10");
        step_once(16'h0072, "R10");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule